// File: doc/BRIEF.md
# Timer channel pin control unit

This block is the pin-facing slice of a four-channel general-purpose timer. Each channel shares one I/O pin between plain GPIO use and the timer, and the channel can work as an input capture or as an output compare. The block takes the free-running count from outside, along with each channel's configuration. It decides which source owns each pin, detects pin edges, latches the count into a capture register when an edge is seen, and sets a flag for each capture or compare event. It also updates a per-channel compare output level.

The last channel can also act as an override source. When its compare matches, every compare-mode channel that has its override mask bit set is forced to that channel's override data bit. The force takes precedence over the channel's own compare action in the same cycle. A data-read output gives software either the live pin level or the data latch, chosen by the direction bit.

Top module: `tpc_port`

## Requirements
- R1: With `tmr_en` low, every pin is GPIO: `pin_oe` equals `dir` and `pin_out` equals `dlatch`. No capture or compare event sets a flag or changes a capture register.
- R2: A channel in capture mode (`is_cmp`=0) leaves its pin under GPIO control. This is also true when its edge select is 00, which disables capture. Its `ovr_mask` bit has no effect on the pin.
- R3: Edge select 01 captures rising edges, 10 captures falling edges and 11 captures both. The pin level passes two synchronizer flops before edge detection, so a change seen at clock edge k is captured at edge k+2. At that edge the capture register loads `cnt_val` and the channel flag sets.
- R4: In capture mode with `dir`=1, edges of the driven data latch value are captured.
- R5: In compare mode, a match of `cnt_val` with the channel's compare value sets the flag one cycle later. This holds even with action 00, and with action 00 and no mask bit the pin stays GPIO.
- R6: In compare mode, a nonzero action makes the pin an output whatever `dir` is, driven by the compare level. On a match the compare level toggles (01), goes low (10) or goes high (11) at the next edge, and otherwise it holds.
- R7: A compare-mode channel with `ovr_mask` set is an output. On a match of the last channel, its compare level takes its `ovr_data` bit.
- R8: When the override force and the channel's own match fall in the same cycle, the override value wins.
- R9: `rd_data` returns `pin_in` when `dir`=0 and `dlatch` when `dir`=1.
- R10: Writing 1 on `flag_clr` clears the flag at the next edge. A set in the same cycle wins over the clear.
- R11: After reset, flags, capture registers and compare levels are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_en | input | 1 | Timer global enable |
| cnt_val | input | CW | Free-running counter value |
| dir | input | NCH | Direction per pin, 1 = output |
| dlatch | input | NCH | GPIO data latch per pin |
| is_cmp | input | NCH | 1 = output compare, 0 = input capture |
| edge_sel | input | 2*NCH | Capture edge select, 2 bits per channel |
| act_sel | input | 2*NCH | Compare action, 2 bits per channel |
| ovr_mask | input | NCH | Override mask per channel |
| ovr_data | input | NCH | Override data per channel |
| cmp_val | input | NCH*CW | Compare value, CW bits per channel |
| pin_in | input | NCH | External pin level |
| flag_clr | input | NCH | Write-1-to-clear strobe for flags |
| pin_out | output | NCH | Pin drive value |
| pin_oe | output | NCH | Pin output enable |
| rd_data | output | NCH | Data register read value |
| flags | output | NCH | Event flags |
| cap_reg | output | NCH*CW | Capture registers, CW bits per channel |

## Verification
Two pairs of events can fall in the same cycle. The override force from the last channel can meet a channel's own compare match, and a flag clear can meet a new capture or compare event. The bench sets channel 0 and the last channel to the same compare value with conflicting action and override data. It also pulses the clear while pin edges are still arriving. The behavioural model applies precedence in its own terms, the override first and the set over the clear, and it is compared with the pin and flag outputs on every clock.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } act_e;

  // Next compare level for an own match.
  function automatic logic oc_next(input logic [1:0] act, input logic cur);
    case (act_e'(act))
      ACT_TOGGLE: oc_next = ~cur;
      ACT_LOW:    oc_next = 1'b0;
      ACT_HIGH:   oc_next = 1'b1;
      default:    oc_next = cur;
    endcase
  endfunction

  // sel[0] enables rising, sel[1] enables falling.
  function automatic logic edge_match(input logic [1:0] sel, input logic now,
                                      input logic was);
    edge_match = (sel[0] & now & ~was) | (sel[1] & ~now & was);
  endfunction

  // Set has precedence over clear.
  function automatic logic flag_next(input logic cur, input logic clr,
                                     input logic set);
    flag_next = set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/tpc_edge_sync.sv
module tpc_edge_sync (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       level_i,
  input  logic [1:0] sel_i,
  output logic       hit_o
);
  import tpc_pkg::*;

  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= level_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign hit_o = edge_match(sel_i, sync_q, prev_q);

endmodule

// File: rtl/tpc_oc_unit.sv
module tpc_oc_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit_i,
  input  logic [1:0] act_i,
  input  logic       force_i,
  input  logic       force_val_i,
  output logic       oc_o
);
  import tpc_pkg::*;

  logic oc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       oc_q <= 1'b0;
    else if (force_i) oc_q <= force_val_i;
    else if (hit_i)   oc_q <= oc_next(act_i, oc_q);
  end

  assign oc_o = oc_q;

  // R8: the override beats the own action in the same cycle
  assert_ovr_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (force_i && hit_i) |=> (oc_o == $past(force_val_i)));

  // R6: a toggle match flips the level
  assert_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && !force_i && act_i == 2'b01) |=> (oc_o != $past(oc_o)));

  // R6: with no event the level holds
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_i && !force_i) |=> $stable(oc_o));

endmodule

// File: rtl/tpc_pin_mux.sv
module tpc_pin_mux (
  input  logic       tmr_en_i,
  input  logic       is_cmp_i,
  input  logic [1:0] act_i,
  input  logic       mask_i,
  input  logic       dir_i,
  input  logic       dlatch_i,
  input  logic       oc_i,
  output logic       oe_o,
  output logic       out_o
);
  logic timer_owns;

  // Ownership priority: enable, then mode, then action or mask, then direction.
  always_comb begin
    timer_owns = 1'b0;
    if (tmr_en_i && is_cmp_i)
      timer_owns = (act_i != 2'b00) || mask_i;
  end

  assign oe_o  = timer_owns | dir_i;
  assign out_o = timer_owns ? oc_i : dlatch_i;

endmodule

// File: rtl/tpc_port.sv
module tpc_port #(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_en,
  input  logic [CW-1:0]     cnt_val,
  input  logic [NCH-1:0]    dir,
  input  logic [NCH-1:0]    dlatch,
  input  logic [NCH-1:0]    is_cmp,
  input  logic [2*NCH-1:0]  edge_sel,
  input  logic [2*NCH-1:0]  act_sel,
  input  logic [NCH-1:0]    ovr_mask,
  input  logic [NCH-1:0]    ovr_data,
  input  logic [NCH*CW-1:0] cmp_val,
  input  logic [NCH-1:0]    pin_in,
  input  logic [NCH-1:0]    flag_clr,
  output logic [NCH-1:0]    pin_out,
  output logic [NCH-1:0]    pin_oe,
  output logic [NCH-1:0]    rd_data,
  output logic [NCH-1:0]    flags,
  output logic [NCH*CW-1:0] cap_reg
);
  import tpc_pkg::*;

  localparam int OVR = NCH - 1;

  logic [NCH-1:0] cmp_hit;
  logic [NCH-1:0] edge_hit;
  logic [NCH-1:0] cap_evt;
  logic [NCH-1:0] oc_lvl;
  logic [NCH-1:0] pin_lvl;
  logic [NCH-1:0] ovr_force;
  logic [NCH-1:0] flag_q;
  logic [CW-1:0]  cap_q [NCH];
  logic           ovr_fire;

  assign ovr_fire = cmp_hit[OVR];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign cmp_hit[i]   = tmr_en & is_cmp[i] & (cnt_val == cmp_val[i*CW +: CW]);
    assign ovr_force[i] = ovr_fire & is_cmp[i] & ovr_mask[i];

    tpc_pin_mux u_mux (
      .tmr_en_i (tmr_en),
      .is_cmp_i (is_cmp[i]),
      .act_i    (act_sel[2*i +: 2]),
      .mask_i   (ovr_mask[i]),
      .dir_i    (dir[i]),
      .dlatch_i (dlatch[i]),
      .oc_i     (oc_lvl[i]),
      .oe_o     (pin_oe[i]),
      .out_o    (pin_out[i])
    );

    // Capture observes the level actually on the pin.
    assign pin_lvl[i] = pin_oe[i] ? pin_out[i] : pin_in[i];

    tpc_edge_sync u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (pin_lvl[i]),
      .sel_i   (edge_sel[2*i +: 2]),
      .hit_o   (edge_hit[i])
    );

    assign cap_evt[i] = tmr_en & ~is_cmp[i] & edge_hit[i];

    tpc_oc_unit u_oc (
      .clk         (clk),
      .rst_n       (rst_n),
      .hit_i       (cmp_hit[i]),
      .act_i       (act_sel[2*i +: 2]),
      .force_i     (ovr_force[i]),
      .force_val_i (ovr_data[i]),
      .oc_o        (oc_lvl[i])
    );

    assign rd_data[i]          = dir[i] ? dlatch[i] : pin_in[i];
    assign cap_reg[i*CW +: CW] = cap_q[i];

    // R1: timer off leaves GPIO in control
    assert_off_gpio_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !tmr_en |-> (pin_oe[i] == dir[i] && pin_out[i] == dlatch[i]));

    // R2: capture mode never takes the pin
    assert_capmode_gpio_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_en && !is_cmp[i]) |-> (pin_oe[i] == dir[i] && pin_out[i] == dlatch[i]));

    // R3: a capture event loads the count and raises the flag
    assert_cap_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[i] |=> (flag_q[i] && cap_q[i] == $past(cnt_val)));

    // R5: a compare match raises the flag
    assert_cmp_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_hit[i] |=> flag_q[i]);

    // R6: nonzero action in compare mode drives the pin
    assert_owned_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_en && is_cmp[i] && act_sel[2*i +: 2] != 2'b00) |-> pin_oe[i]);

    // R10: a lone clear empties the flag
    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr[i] && !cap_evt[i] && !cmp_hit[i]) |=> !flag_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      for (int i = 0; i < NCH; i++) cap_q[i] <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        flag_q[i] <= flag_next(flag_q[i], flag_clr[i], cap_evt[i] | cmp_hit[i]);
        if (cap_evt[i]) cap_q[i] <= cnt_val;
      end
    end
  end

  assign flags = flag_q;

  // R1: with the timer off, flags only fall
  assert_off_flags_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_en |=> (flags == ($past(flags) & ~$past(flag_clr))));

endmodule

// File: tb/tpc_port_tb.sv
module tpc_port_tb;
  localparam int N = 4;
  localparam int W = 16;
  localparam time TCK = 20ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tmr_en = 1'b0;
  logic [W-1:0] cnt = '0;
  logic [N-1:0] dir = '0, dlatch = '0, is_cmp = '0, ovr_mask = '0, ovr_data = '0;
  logic [N-1:0] pin_in = '0, flag_clr = '0;
  logic [2*N-1:0] edge_sel = '0, act_sel = '0;
  logic [N*W-1:0] cmp_val = '0;
  logic [N-1:0] pin_out, pin_oe, rd_data, flags;
  logic [N*W-1:0] cap_reg;

  int total = 0, bad = 0;
  bit done = 0;
  string cur = "R11";

  // behavioural reference state
  logic m_flag [N];
  logic [W-1:0] m_cap [N];
  logic m_oc [N];
  logic [7:0] hist [N]; // bit0 newest pin sample

  always #(TCK/2) clk = ~clk;

  tpc_port #(.NCH(N), .CW(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .cnt_val(cnt), .dir(dir),
    .dlatch(dlatch), .is_cmp(is_cmp), .edge_sel(edge_sel), .act_sel(act_sel),
    .ovr_mask(ovr_mask), .ovr_data(ovr_data), .cmp_val(cmp_val), .pin_in(pin_in),
    .flag_clr(flag_clr), .pin_out(pin_out), .pin_oe(pin_oe), .rd_data(rd_data),
    .flags(flags), .cap_reg(cap_reg)
  );

  function automatic logic takes_pin(int i);
    return tmr_en && is_cmp[i] && (act_sel[2*i +: 2] != 2'b00 || ovr_mask[i]);
  endfunction

  task automatic chk(string what, logic [63:0] a, logic [63:0] e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", cur, what, a, e);
    end
  endtask

  task automatic check_all();
    logic [N-1:0] eo, ep, er, ef;
    logic [N*W-1:0] ec;
    for (int i = 0; i < N; i++) begin
      eo[i] = takes_pin(i) ? 1'b1 : dir[i];
      ep[i] = takes_pin(i) ? m_oc[i] : dlatch[i];
      er[i] = (dir[i] == 1'b0) ? pin_in[i] : dlatch[i]; // R9
      ef[i] = m_flag[i];
      ec[i*W +: W] = m_cap[i];
    end
    chk("pin_oe", 64'(pin_oe), 64'(eo));
    chk("pin_out", 64'(pin_out), 64'(ep));
    chk("rd_data", 64'(rd_data), 64'(er));
    chk("flags", 64'(flags), 64'(ef));
    chk("cap_reg", 64'(cap_reg), 64'(ec));
  endtask

  task automatic step();
    logic lvl [N];
    logic hit [N];
    logic nw, was, capt, ovr;
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      if (takes_pin(i))   lvl[i] = m_oc[i];
      else if (dir[i])    lvl[i] = dlatch[i];
      else                lvl[i] = pin_in[i];
      hit[i] = tmr_en && is_cmp[i] && (cnt == cmp_val[i*W +: W]);
    end
    ovr = hit[N-1];
    for (int i = 0; i < N; i++) begin
      nw  = hist[i][1];
      was = hist[i][2];
      case (edge_sel[2*i +: 2])
        2'd1: capt = nw && !was;
        2'd2: capt = was && !nw;
        2'd3: capt = (nw != was);
        default: capt = 1'b0;
      endcase
      capt = capt && tmr_en && !is_cmp[i];
      if (capt) m_cap[i] = cnt;
      if (capt || hit[i]) m_flag[i] = 1'b1;
      else if (flag_clr[i]) m_flag[i] = 1'b0;
      if (ovr && is_cmp[i] && ovr_mask[i]) m_oc[i] = ovr_data[i];
      else if (hit[i]) begin
        case (act_sel[2*i +: 2])
          2'd1: m_oc[i] = !m_oc[i];
          2'd2: m_oc[i] = 1'b0;
          2'd3: m_oc[i] = 1'b1;
          default: ;
        endcase
      end
      hist[i] = {hist[i][6:0], lvl[i]};
    end
    #2;
    check_all();
    cnt = cnt + 16'd1;
  endtask

  task automatic cmp_at(int i, int d);
    cmp_val[i*W +: W] = cnt + 16'(d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_flag[i] = 0; m_cap[i] = '0; m_oc[i] = 0; hist[i] = '0;
    end
    repeat (3) @(posedge clk);
    #2;
    cur = "R11"; // reset state
    check_all();
    rst_n = 1'b1;

    // R1: timer off, matches and pin edges must do nothing
    cur = "R1";
    dir = 4'b1010; dlatch = 4'b0110; is_cmp = 4'b1111; act_sel = 8'hFF;
    ovr_mask = 4'b1111;
    for (int i = 0; i < N; i++) cmp_at(i, 2);
    for (int k = 0; k < 6; k++) begin pin_in = ~pin_in; step(); end
    is_cmp = 4'b0000; edge_sel = 8'hFF;
    for (int k = 0; k < 6; k++) begin pin_in = ~pin_in; step(); end

    // R2 and R9: capture mode with select 00, mask ignored, read path
    cur = "R2";
    tmr_en = 1'b1; edge_sel = 8'h00; ovr_mask = 4'b1111; act_sel = 8'hFF;
    for (int k = 0; k < 8; k++) begin
      cur = (k < 4) ? "R2" : "R9";
      dir = 4'(k * 5); dlatch = 4'(k * 3); pin_in = 4'(k * 7 + 1);
      step();
    end

    // R3: rising on ch0, falling on ch1, both on ch2, none on ch3
    cur = "R3";
    dir = '0; ovr_mask = '0; pin_in = '0;
    edge_sel = {2'b00, 2'b11, 2'b10, 2'b01};
    for (int k = 0; k < 24; k++) begin
      if (k % 3 == 0) pin_in = ~pin_in;
      step();
    end

    // R10: clear alone, then clear racing new edges (set wins)
    cur = "R10";
    flag_clr = 4'b1111; step(); flag_clr = '0; step();
    for (int k = 0; k < 8; k++) begin
      if (k % 2 == 0) pin_in = ~pin_in;
      flag_clr = 4'b1111;
      step();
    end
    flag_clr = '0; step();

    // R4: output direction, edges come from the data latch
    cur = "R4";
    flag_clr = 4'b1111; step(); flag_clr = '0;
    dir = 4'b1111; edge_sel = 8'hFF;
    for (int k = 0; k < 12; k++) begin
      if (k % 3 == 1) dlatch = ~dlatch;
      step();
    end

    // R5: compare with action 00 flags but leaves pins GPIO
    cur = "R5";
    flag_clr = 4'b1111; step(); flag_clr = '0;
    is_cmp = 4'b1111; act_sel = 8'h00; ovr_mask = '0; dir = 4'b0101;
    for (int i = 0; i < N; i++) cmp_at(i, i + 1);
    for (int k = 0; k < 6; k++) step();

    // R6: high on ch0, low on ch1, toggle on ch2 and ch3, dir=0
    cur = "R6";
    flag_clr = 4'b1111; step(); flag_clr = '0;
    dir = '0; act_sel = {2'b01, 2'b01, 2'b10, 2'b11};
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < N; i++) cmp_at(i, 1 + i % 2);
      for (int k = 0; k < 3; k++) step();
    end

    // R7: channel 3 forces masked compare channels, capture channel ignores mask
    cur = "R7";
    is_cmp = 4'b1011; act_sel = {2'b01, 2'b00, 2'b00, 2'b00};
    ovr_mask = 4'b0111; ovr_data = 4'b0101; edge_sel = 8'h00;
    cmp_val = '0;
    for (int r = 0; r < 3; r++) begin
      cmp_at(3, 2);
      for (int k = 0; k < 3; k++) step();
      ovr_data = ~ovr_data;
    end

    // R8: ch0 own match and override on the same cycle
    cur = "R8";
    is_cmp = 4'b1111; act_sel = {2'b01, 2'b00, 2'b00, 2'b11};
    ovr_mask = 4'b0001; ovr_data = 4'b0000;
    cmp_at(0, 2); cmp_at(3, 2);
    for (int k = 0; k < 4; k++) step();
    act_sel[1:0] = 2'b10; ovr_data = 4'b0001;
    cmp_at(0, 2); cmp_at(3, 2);
    for (int k = 0; k < 4; k++) step();
    // own match alone still acts
    cmp_at(0, 2); cmp_val[3*W +: W] = cnt + 16'd9;
    for (int k = 0; k < 3; k++) step();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule